// File: doc/BRIEF.md
# Repeated-Addition Multiplier Controller

This block multiplies two unsigned operands without a hardware multiplier. It adds the first operand into an accumulator once for each unit of the second operand, counting the second operand down to zero. A seven-state controller sequences the work as separate steps: capture a, capture b and clear the accumulator, evaluate the loop condition, accumulate, decrement, and re-evaluate. Every step reports completion through its own done flag. The controller leaves a state only when that flag is high and otherwise stays where it is.

The loop test `b != 0` is not taken straight from the counter. A dedicated step computes it and writes it into a one-bit condition register, and the branch reads that register. The accumulate step models a multi-cycle adder: a cycle counter holds the write back until `ADD_LAT` cycles have passed. Software-style use is simple. Raise `go` with the operands stable. Wait for `done`. Read `product`. Drop `go` to release the block.

Top module: `rep_add_mult`

## Requirements
- R1: After reset, `done` is 0, `product` is 0, and the controller waits in the operand-a capture state.
- R2: When b is captured, the accumulator is cleared to zero in the same write, so a new operation never inherits the previous product.
- R3: A `b_in` of 0 yields a `product` of 0 without entering the accumulate loop, with `done` rising 4 rising edges after the edge that samples `go`.
- R4: For operands held stable from `go` until `done`, `product` equals `a_in * b_in` as a 2*WIDTH-bit unsigned value, and each accumulate write adds exactly a to the accumulator.
- R5: `done` first rises exactly 4 + b*(ADD_LAT+5) rising edges after the edge at which `go` is first sampled high in the capture state. This count shows that every step waited for its own done.
- R6: While `go` stays high after completion, `done` stays 1 and `product` does not change.
- R7: Once `go` is low while `done` is 1, `done` is 0 after the next rising edge and a new `go` is accepted on the edge after that.
- R8: The controller state changes only on an edge where the current step's done flag is high; otherwise it holds.
- R9: Each pass through the decrement step lowers the stored b by exactly one.
- R10: Each condition-evaluation write leaves the condition register equal to (stored b != 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request; held high until `done`, then dropped to release |
| a_in | input | WIDTH | Operand added into the accumulator |
| b_in | input | WIDTH | Operand giving the number of additions |
| product | output | 2*WIDTH | Accumulator value, the product once `done` is high |
| done | output | 1 | Registered completion flag, high in the finish state |

## Verification
The bound checker watches, on every cycle, the step-local rules: the state holds while a step is unfinished, each accumulate write adds a, each decrement subtracts one, each condition write matches the stored b, the accumulator clears on capture, and the hold and release of `done`. Only the bench's scenarios can show the end-to-end results. These are that the final product matches a reference multiplication, and that the total latency equals the formula in R5 for zero, one, maximum and random operands. That latency is what confirms no step skipped its wait. Back-to-back operations with immediate re-arming of `go` are also exercised only by the bench.

// File: rtl/rm_pkg.sv
package rm_pkg;

  // Controller states; order matches the sequence the loop walks through.
  typedef enum logic [2:0] {
    ST_GRAB_A   = 3'd0,
    ST_GRAB_B   = 3'd1,
    ST_TEST     = 3'd2,
    ST_ADD      = 3'd3,
    ST_DEC      = 3'd4,
    ST_RETEST   = 3'd5,
    ST_FINISH   = 3'd6
  } rm_state_e;

  function automatic logic is_test_state(rm_state_e s);
    return (s == ST_TEST) || (s == ST_RETEST);
  endfunction

endpackage

// File: rtl/rm_step_reg.sv
// Register with a write enable and a done flag that follows one cycle
// after each write.
module rm_step_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      done <= 1'b0;
    end else begin
      if (we) q <= d;
      done <= we;
    end
  end

endmodule

// File: rtl/rm_lat_count.sv
// Cycle counter for a step with a fixed latency. While active it counts
// up, and it fires once, on the LAT-th cycle of residence.
module rm_lat_count #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic fire
);

  localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);
  localparam logic [CW-1:0] SAT  = CW'(LAT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (cnt != SAT) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign fire = active && (cnt == LAST);

endmodule

// File: rtl/rm_ctrl.sv
// Explicit controller: each branch tests exclusive conditions guarded by
// the step's done flag; the final else keeps the state.
module rm_ctrl
  import rm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step_done,
  input  logic      cond,
  output rm_state_e st,
  output rm_state_e st_nxt
);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_GRAB_A: begin
        if (step_done) st_nxt = ST_GRAB_B;
        else           st_nxt = st;
      end
      ST_GRAB_B: begin
        if (step_done) st_nxt = ST_TEST;
        else           st_nxt = st;
      end
      ST_TEST, ST_RETEST: begin
        if (step_done && cond)       st_nxt = ST_ADD;
        else if (step_done && !cond) st_nxt = ST_FINISH;
        else                         st_nxt = st;
      end
      ST_ADD: begin
        if (step_done) st_nxt = ST_DEC;
        else           st_nxt = st;
      end
      ST_DEC: begin
        if (step_done) st_nxt = ST_RETEST;
        else           st_nxt = st;
      end
      ST_FINISH: begin
        if (step_done) st_nxt = ST_GRAB_A;
        else           st_nxt = st;
      end
      default: st_nxt = ST_GRAB_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_GRAB_A;
    else     st <= st_nxt;
  end

endmodule

// File: rtl/rep_add_mult.sv
module rep_add_mult
  import rm_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int ADD_LAT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [WIDTH-1:0]   a_in,
  input  logic [WIDTH-1:0]   b_in,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  localparam int PW = 2 * WIDTH;

  rm_state_e st, st_nxt;

  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q, b_d;
  logic             b_we, b_done;
  logic [0:0]       cond_q, cond_d;
  logic             cond_we, cond_done;
  logic [PW-1:0]    acc_q, acc_d;
  logic             acc_we, acc_done, add_fire;
  logic             step_done;
  logic             done_q;

  // Operand a: loaded every cycle of the capture state, held elsewhere.
  always_ff @(posedge clk) begin
    if (rst)                  a_q <= '0;
    else if (st == ST_GRAB_A) a_q <= a_in;
  end

  // Down-counting b: captured, then decremented once per loop pass.
  assign b_we = ((st == ST_GRAB_B) || (st == ST_DEC)) && !b_done;
  assign b_d  = (st == ST_GRAB_B) ? b_in : (b_q - WIDTH'(1));

  rm_step_reg #(.DW(WIDTH)) u_b_reg (
    .clk(clk), .rst(rst), .we(b_we), .d(b_d), .q(b_q), .done(b_done)
  );

  // Registered loop condition.
  assign cond_we = is_test_state(st) && !cond_done;
  assign cond_d  = 1'(b_q != '0);

  rm_step_reg #(.DW(1)) u_cond_reg (
    .clk(clk), .rst(rst), .we(cond_we), .d(cond_d), .q(cond_q), .done(cond_done)
  );

  // Accumulator: cleared with the b capture, added to after ADD_LAT cycles.
  rm_lat_count #(.LAT(ADD_LAT)) u_add_lat (
    .clk(clk), .rst(rst), .active(st == ST_ADD), .fire(add_fire)
  );

  assign acc_we = add_fire || ((st == ST_GRAB_B) && !b_done);
  assign acc_d  = (st == ST_GRAB_B) ? '0 : (acc_q + PW'(a_q));

  rm_step_reg #(.DW(PW)) u_acc_reg (
    .clk(clk), .rst(rst), .we(acc_we), .d(acc_d), .q(acc_q), .done(acc_done)
  );

  // Done flag of the step invoked in the current state.
  always_comb begin
    case (st)
      ST_GRAB_A:           step_done = go;
      ST_GRAB_B, ST_DEC:   step_done = b_done;
      ST_TEST, ST_RETEST:  step_done = cond_done;
      ST_ADD:              step_done = acc_done;
      ST_FINISH:           step_done = !go;
      default:             step_done = 1'b1;
    endcase
  end

  rm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .step_done(step_done), .cond(cond_q[0]),
    .st(st), .st_nxt(st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= (st_nxt == ST_FINISH);
  end

  assign done    = done_q;
  assign product = acc_q;

endmodule

// File: rtl/rep_add_mult_chk.sv
module rep_add_mult_chk
  import rm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               go,
  input logic               done,
  input logic [2*WIDTH-1:0] product,
  input rm_state_e          st,
  input logic               step_done,
  input logic [WIDTH-1:0]   a_q,
  input logic [WIDTH-1:0]   b_q,
  input logic               b_we,
  input logic [0:0]         cond_q,
  input logic               cond_we,
  input logic               acc_we
);

  p_hold_state_r8: assert property (@(posedge clk) disable iff (rst)
    !step_done |=> st == $past(st));

  p_acc_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GRAB_B && acc_we) |=> product == '0);

  p_acc_add_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADD && acc_we) |=> product == $past(product) + (2*WIDTH)'($past(a_q)));

  p_dec_one_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEC && b_we) |=> b_q == $past(b_q) - WIDTH'(1));

  p_cond_match_r10: assert property (@(posedge clk) disable iff (rst)
    cond_we |=> cond_q[0] == ($past(b_q) != '0));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && go) |=> (done && $stable(product)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> !done);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!done && st == ST_GRAB_A));

endmodule

bind rep_add_mult rep_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .go(go), .done(done), .product(product),
  .st(st), .step_done(step_done), .a_q(a_q), .b_q(b_q), .b_we(b_we),
  .cond_q(cond_q), .cond_we(cond_we), .acc_we(acc_we)
);

// File: tb/sim_rep_add_mult.sv
module sim_rep_add_mult;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int LAT = 3;
  localparam int PW  = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          go  = 1'b0;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic [PW-1:0] product;
  logic          done;

  typedef struct {
    logic [W-1:0]  b;
    logic [PW-1:0] prod;
    int            lat;
    int            start;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  bit   done_prev = 1'b0;
  bit   finished  = 1'b0;

  rep_add_mult #(.WIDTH(W), .ADD_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .go(go), .a_in(a_in), .b_in(b_in),
    .product(product), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Monitor: pops the scoreboard when done rises and compares result and latency.
  always @(negedge clk) begin
    if (!rst && done && !done_prev) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.b == '0) check(product == e.prod, "R3 product", product, e.prod);
        else           check(product == e.prod, "R4 product", product, e.prod);
        check((cyc - e.start - 1) == e.lat, "R5 latency", cyc - e.start - 1, e.lat);
      end
    end
    done_prev = done;
  end

  // Driver: starts one operation, holds go for hold cycles after done, releases.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int hold);
    exp_t e;
    logic [PW-1:0] fin;
    @(negedge clk);
    a_in = a;
    b_in = b;
    go   = 1'b1;
    e.b     = b;
    e.prod  = PW'(a) * PW'(b);
    e.lat   = 4 + int'(b) * (LAT + 5);
    e.start = cyc;
    sb.push_back(e);
    do @(negedge clk); while (!done);
    fin = product;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(done == 1'b1, "R6 done held", done, 1);
      check(product == fin, "R6 product stable", product, fin);
    end
    go = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R7 release", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports.
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(product == '0, "R1 product after reset", product, 0);
    // R3: zero multiplier, including after a nonzero product (R2 clear).
    run_op(8'd5, 8'd0, 0);
    run_op(8'd0, 8'd0, 1);
    run_op(8'd7, 8'd6, 2);
    run_op(8'd9, 8'd0, 0);   // R2: accumulator cleared from 42 to 0
    run_op(8'd0, 8'd7, 0);
    run_op(8'd1, 8'd1, 3);
    run_op(8'd255, 8'd1, 0);
    run_op(8'd3, 8'd4, 1);
    run_op(8'd255, 8'd255, 2);
    // R7: immediate re-arm after release, then random operands.
    for (int k = 0; k < 12; k++) begin
      run_op(W'($urandom), W'($urandom), k % 3);
    end
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R5 all results seen", sb.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule